// File: doc/BRIEF.md
# Register Shift and Rotate Execution Unit

This unit decodes one 16-bit instruction word and executes its shift or rotate on a data register operand. It takes the instruction, the current value of the destination register, the value of the register that may hold a count, and the current extend flag. One clock cycle later it presents the new register value and the five condition flags: extend, negative, zero, overflow and carry.

Four operation classes are available: arithmetic shift, logical shift, plain rotate, and rotate through the extend flag. Each runs to the left or to the right on a byte, word or long operand. The count is either a short immediate in the instruction or the low bits of a count register. The block also decodes the two register selectors from the instruction word without a clock, so that a register file can supply the operand values in the same cycle.

Top module: `shrot_unit`

## Requirements
- R1: An instruction is accepted only when bits 15..12 equal 4'b1110 and the size field (bits 7..6) is not 2'b11. An instruction that fails this check raises `out_illegal` for one cycle, leaves `out_valid` low, and does not change `result` or the flags.
- R2: When bit 5 is 0, bits 11..9 give an immediate count from 1 to 7, and the value 3'b000 means a count of 8.
- R3: When bit 5 is 1, the count is the count register value modulo 64. `cnt_sel` always shows bits 11..9, `dst_sel` shows bits 2..0, and `cnt_from_reg` shows bit 5. These three outputs are combinational.
- R4: Bit 8 selects the direction. A 1 moves bits toward the most significant end (left) and a 0 moves them toward bit 0 (right).
- R5: Bits 4..3 select the operation: 2'b00 arithmetic shift (a right shift copies the sign bit), 2'b01 logical shift (zeros enter), 2'b10 rotate through extend, 2'b11 plain rotate.
- R6: Size codes are 2'b00 byte (8 bits), 2'b01 word (16 bits) and 2'b10 long (32 bits). Only the low bits of the selected size change. The upper bits of `result` equal those of `dst_val`.
- R7: `flag_c` is the last bit moved out of the operand. It is 0 when the count is zero.
- R8: For shifts and for rotate through extend with a nonzero count, `flag_x` equals `flag_c`. For plain rotates and for zero counts, `flag_x` equals `x_in`.
- R9: `flag_n` is the most significant bit of the sized result, and `flag_z` is 1 exactly when the sized result is zero.
- R10: `flag_v` is 1 only for an arithmetic left shift during which the operand's most significant bit took a value different from its original value at any step. Otherwise it is 0.
- R11: Rotate through extend treats the operand and the extend flag as one ring of size+1 bits. The extend flag sits just above the operand's most significant bit.
- R12: `out_valid` rises one cycle after an accepted `in_valid` and lasts one cycle. After reset, `result` and all flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands present this cycle |
| instr | input | 16 | Instruction word |
| dst_val | input | 32 | Destination register value (also the source operand) |
| cnt_val | input | 32 | Count register value |
| x_in | input | 1 | Current extend flag |
| dst_sel | output | 3 | Destination register number (bits 2..0) |
| cnt_sel | output | 3 | Count register number or immediate field (bits 11..9) |
| cnt_from_reg | output | 1 | Count comes from a register |
| out_valid | output | 1 | Result and flags updated |
| out_illegal | output | 1 | Last instruction rejected |
| result | output | 32 | New destination register value |
| flag_x | output | 1 | Extend flag |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
An internal fault in the step loop, such as a wrong fill bit, a misplaced ring position for the extend flag, or a wrong most-significant-bit index for a size, shows up on the result or flag outputs in the cycle after the instruction that triggers it. Nothing carries over between instructions except the held outputs. A fault therefore stays visible only for that one result, so the count range (zero, exactly the size, more than the size, above 64) is swept together with each size and operation. A decode fault shows at once on the selector outputs, or on `out_illegal` in the next cycle.

// File: rtl/shrot_pkg.sv
package shrot_pkg;

    localparam int DW    = 32;
    localparam int CNT_W = 6;
    localparam int MAXC  = (1 << CNT_W) - 1;

    typedef enum logic [1:0] {
        OP_ASH = 2'b00,
        OP_LSH = 2'b01,
        OP_RXT = 2'b10,
        OP_ROT = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_BAD  = 2'b11
    } size_e;

    typedef struct packed {
        logic             legal;
        logic             left;
        op_e              op;
        size_e            sz;
        logic             from_reg;
        logic [2:0]       cnt_field;
        logic [2:0]       dst_field;
    } dec_t;

    typedef struct packed {
        logic x;
        logic n;
        logic z;
        logic v;
        logic c;
    } flags_t;

    function automatic logic [DW-1:0] size_mask(size_e s);
        case (s)
            SZ_BYTE: return DW'(32'h0000_00FF);
            SZ_WORD: return DW'(32'h0000_FFFF);
            default: return {DW{1'b1}};
        endcase
    endfunction

    function automatic logic [4:0] msb_pos(size_e s);
        case (s)
            SZ_BYTE: return 5'd7;
            SZ_WORD: return 5'd15;
            default: return 5'd31;
        endcase
    endfunction

endpackage

// File: rtl/shrot_decode.sv
module shrot_decode
    import shrot_pkg::*;
(
    input  logic [15:0]      instr,
    input  logic [DW-1:0]    cnt_val,
    output dec_t             dec,
    output logic [CNT_W-1:0] count
);
    always_comb begin
        dec.legal     = (instr[15:12] == 4'b1110) && (instr[7:6] != SZ_BAD);
        dec.left      = instr[8];
        dec.op        = op_e'(instr[4:3]);
        dec.sz        = size_e'(instr[7:6]);
        dec.from_reg  = instr[5];
        dec.cnt_field = instr[11:9];
        dec.dst_field = instr[2:0];
        if (instr[5])
            count = cnt_val[CNT_W-1:0];
        else if (instr[11:9] == 3'b000)
            count = CNT_W'(8);
        else
            count = CNT_W'(instr[11:9]);
    end
endmodule

// File: rtl/shrot_core.sv
module shrot_core
    import shrot_pkg::*;
(
    input  logic [DW-1:0]    opnd,
    input  logic [CNT_W-1:0] count,
    input  logic             left,
    input  op_e              op,
    input  size_e            sz,
    input  logic             x_in,
    output logic [DW-1:0]    res,
    output flags_t           flg
);
    logic [DW-1:0] mask;
    logic [4:0]    mp;
    logic [DW-1:0] cur, nxt;
    logic          xr, cr, vr, orig, outb;

    always_comb begin
        mask = size_mask(sz);
        mp   = msb_pos(sz);
        cur  = opnd & mask;
        orig = cur[mp];
        xr   = x_in;
        cr   = 1'b0;
        vr   = 1'b0;
        outb = 1'b0;
        nxt  = '0;
        for (int i = 0; i < MAXC; i++) begin
            if (CNT_W'(i) < count) begin
                if (left) begin
                    outb = cur[mp];
                    nxt  = (cur << 1) & mask;
                    case (op)
                        OP_ROT:  nxt[0] = outb;
                        OP_RXT: begin
                            nxt[0] = xr;
                            xr     = outb;
                        end
                        default: xr = outb;
                    endcase
                    if (op == OP_ASH && nxt[mp] != orig)
                        vr = 1'b1;
                end else begin
                    outb = cur[0];
                    nxt  = cur >> 1;
                    case (op)
                        OP_ASH: begin
                            nxt[mp] = cur[mp];
                            xr      = outb;
                        end
                        OP_LSH:  xr = outb;
                        OP_ROT:  nxt[mp] = outb;
                        default: begin
                            nxt[mp] = xr;
                            xr      = outb;
                        end
                    endcase
                end
                cr  = outb;
                cur = nxt;
            end
        end
        res   = (opnd & ~mask) | cur;
        flg.x = xr;
        flg.n = cur[mp];
        flg.z = (cur == '0);
        flg.v = vr;
        flg.c = cr;
    end
endmodule

// File: rtl/shrot_unit.sv
module shrot_unit
    import shrot_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  logic [15:0] instr,
    input  logic [31:0] dst_val,
    input  logic [31:0] cnt_val,
    input  logic        x_in,
    output logic [2:0]  dst_sel,
    output logic [2:0]  cnt_sel,
    output logic        cnt_from_reg,
    output logic        out_valid,
    output logic        out_illegal,
    output logic [31:0] result,
    output logic        flag_x,
    output logic        flag_n,
    output logic        flag_z,
    output logic        flag_v,
    output logic        flag_c
);
    dec_t             dec;
    logic [CNT_W-1:0] count;
    logic [DW-1:0]    res_c;
    flags_t           flg_c, flg_q;
    logic [DW-1:0]    res_q;
    logic             vld_q, ill_q;

    shrot_decode u_dec (
        .instr   (instr),
        .cnt_val (cnt_val),
        .dec     (dec),
        .count   (count)
    );

    shrot_core u_core (
        .opnd  (dst_val),
        .count (count),
        .left  (dec.left),
        .op    (dec.op),
        .sz    (dec.sz),
        .x_in  (x_in),
        .res   (res_c),
        .flg   (flg_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            ill_q <= 1'b0;
            res_q <= '0;
            flg_q <= '0;
        end else begin
            vld_q <= in_valid && dec.legal;
            ill_q <= in_valid && !dec.legal;
            if (in_valid && dec.legal) begin
                res_q <= res_c;
                flg_q <= flg_c;
            end
        end
    end

    assign dst_sel      = dec.dst_field;
    assign cnt_sel      = dec.cnt_field;
    assign cnt_from_reg = dec.from_reg;
    assign out_valid    = vld_q;
    assign out_illegal  = ill_q;
    assign result       = res_q;
    assign flag_x       = flg_q.x;
    assign flag_n       = flg_q.n;
    assign flag_z       = flg_q.z;
    assign flag_v       = flg_q.v;
    assign flag_c       = flg_q.c;

    p_latency_r12: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));
    p_reject_r1: assert property (@(posedge clk) disable iff (rst)
        in_valid && instr[15:12] != 4'b1110 |=> out_illegal && !out_valid);
    p_hold_r1: assert property (@(posedge clk) disable iff (rst)
        out_illegal |-> $stable(result));
    p_upper_byte_r6: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.legal && dec.sz == SZ_BYTE |=> result[31:8] == $past(dst_val[31:8]));
    p_v_clear_r10: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.legal && !(dec.left && dec.op == OP_ASH) |=> !flag_v);
    p_x_rot_r8: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.legal && dec.op == OP_ROT |=> flag_x == $past(x_in));
    p_c_zero_r7: assert property (@(posedge clk) disable iff (rst)
        in_valid && dec.legal && count == '0 |=> !flag_c);
endmodule

// File: tb/sim_shrot_unit.sv
module sim_shrot_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [15:0] instr = '0;
    logic [31:0] dst_val = '0;
    logic [31:0] cnt_val = '0;
    logic        x_in = 1'b0;
    logic [2:0]  dst_sel, cnt_sel;
    logic        cnt_from_reg, out_valid, out_illegal;
    logic [31:0] result;
    logic        flag_x, flag_n, flag_z, flag_v, flag_c;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    shrot_unit u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
        .dst_val(dst_val), .cnt_val(cnt_val), .x_in(x_in),
        .dst_sel(dst_sel), .cnt_sel(cnt_sel), .cnt_from_reg(cnt_from_reg),
        .out_valid(out_valid), .out_illegal(out_illegal), .result(result),
        .flag_x(flag_x), .flag_n(flag_n), .flag_z(flag_z),
        .flag_v(flag_v), .flag_c(flag_c)
    );

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // expected {result, x, n, z, v, c} computed with wide arithmetic
    function automatic logic [36:0] model(logic [15:0] iw, logic [31:0] d,
                                           logic [31:0] cv, logic xi);
        int          w, cnt, k, nr;
        logic [63:0] mask, val, r, sx, ring, rm, ring2, top;
        logic        c, x, v;
        w    = (iw[7:6] == 2'b00) ? 8 : (iw[7:6] == 2'b01) ? 16 : 32;
        mask = (64'h1 << w) - 1;
        val  = {32'h0, d} & mask;
        cnt  = iw[5] ? int'(cv[5:0]) : (iw[11:9] == 0 ? 8 : int'(iw[11:9]));
        r = val; c = 1'b0; x = xi; v = 1'b0;
        if (cnt != 0) begin
            case (iw[4:3])
                2'b00, 2'b01: begin
                    if (iw[8]) begin
                        r = (val << cnt) & mask;
                        c = (cnt <= w) ? val[w-cnt] : 1'b0;
                        if (iw[4:3] == 2'b00) begin
                            if (cnt >= w) v = (val != 0);
                            else begin
                                top = val >> (w - 1 - cnt);
                                v = !(top == 0 || top == ((64'h1 << (cnt + 1)) - 1));
                            end
                        end
                    end else if (iw[4:3] == 2'b01) begin
                        r = val >> cnt;
                        c = (cnt <= w) ? val[cnt-1] : 1'b0;
                    end else begin
                        sx = val | (val[w-1] ? ~mask : 64'h0);
                        r  = 64'($signed(sx) >>> cnt) & mask;
                        c  = sx[cnt-1];
                    end
                    x = c;
                end
                2'b11: begin
                    k = cnt % w;
                    if (iw[8]) r = ((val << k) | (val >> (w - k))) & mask;
                    else       r = ((val >> k) | (val << (w - k))) & mask;
                    c = iw[8] ? r[0] : r[w-1];
                end
                default: begin
                    nr   = w + 1;
                    k    = cnt % nr;
                    rm   = (64'h1 << nr) - 1;
                    ring = ({63'h0, xi} << w) | val;
                    if (iw[8]) ring2 = ((ring << k) | (ring >> (nr - k))) & rm;
                    else       ring2 = ((ring >> k) | (ring << (nr - k))) & rm;
                    r = ring2 & mask;
                    x = ring2[w];
                    c = x;
                end
            endcase
        end
        return {(d & ~mask[31:0]) | r[31:0], x, r[w-1], (r == 0), v, c};
    endfunction

    task automatic apply(logic [15:0] iw, logic [31:0] d, logic [31:0] cv, logic xi,
                         string tag);
        logic [36:0] e;
        @(negedge clk);
        instr = iw; dst_val = d; cnt_val = cv; x_in = xi; in_valid = 1'b1;
        e = model(iw, d, cv, xi);
        @(negedge clk);
        in_valid = 1'b0;
        chk({tag, " R12 valid"}, {31'h0, out_valid}, 32'h1);
        chk({tag, " R6 result"}, result, e[36:5]);
        chk({tag, " R8 x"}, {31'h0, flag_x}, {31'h0, e[4]});
        chk({tag, " R9 nz"}, {30'h0, flag_n, flag_z}, {30'h0, e[3:2]});
        chk({tag, " R10 v"}, {31'h0, flag_v}, {31'h0, e[1]});
        chk({tag, " R7 c"}, {31'h0, flag_c}, {31'h0, e[0]});
    endtask

    function automatic logic [15:0] mk(logic [2:0] cf, logic l, logic [1:0] sz,
                                       logic fr, logic [1:0] op, logic [2:0] dr);
        return {4'b1110, cf, l, sz, fr, op, dr};
    endfunction

    initial begin
        #4_000_000;
        n_chk++; n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] held;
        logic [15:0] iw;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        chk("R12 reset valid", {31'h0, out_valid}, 32'h0);
        chk("R12 reset result", result, 32'h0);
        chk("R12 reset flags", {27'h0, flag_x, flag_n, flag_z, flag_v, flag_c}, 32'h0);

        // R3 selectors
        instr = mk(3'd5, 1'b0, 2'b01, 1'b1, 2'b01, 3'd6);
        #1;
        chk("R3 dst_sel", {29'h0, dst_sel}, 32'd6);
        chk("R3 cnt_sel", {29'h0, cnt_sel}, 32'd5);
        chk("R3 cnt_from_reg", {31'h0, cnt_from_reg}, 32'h1);

        // R2 immediate 000 means 8: logical left by 8 on word
        apply(mk(3'd0, 1'b1, 2'b01, 1'b0, 2'b01, 3'd0), 32'hAAAA_1234, 0, 1'b0, "R2 imm8");
        chk("R2 imm8 value", result, 32'hAAAA_3400);
        // R3 register count 67 -> 3
        apply(mk(3'd1, 1'b0, 2'b10, 1'b1, 2'b01, 3'd0), 32'h8000_0010, 32'd67, 1'b0, "R3 mod64");
        chk("R3 mod64 value", result, 32'h1000_0002);
        // R5 arithmetic right byte keeps sign; R6 upper bits kept
        apply(mk(3'd2, 1'b0, 2'b00, 1'b0, 2'b00, 3'd0), 32'h1234_5681, 0, 1'b0, "R5 asr");
        chk("R5 asr value", result, 32'h1234_56E0);
        // R10 arithmetic left overflow
        apply(mk(3'd1, 1'b1, 2'b00, 1'b0, 2'b00, 3'd0), 32'h0000_0040, 0, 1'b0, "R10 asl");
        chk("R10 asl v set", {31'h0, flag_v}, 32'h1);
        // R7 zero count: C clear, X kept
        apply(mk(3'd0, 1'b1, 2'b10, 1'b1, 2'b00, 3'd0), 32'hFFFF_FFFF, 32'd64, 1'b1, "R7 zero");
        chk("R7 zero c", {31'h0, flag_c}, 32'h0);
        // R8 plain rotate keeps X
        apply(mk(3'd1, 1'b0, 2'b00, 1'b0, 2'b11, 3'd0), 32'h0000_0001, 0, 1'b0, "R8 rot");
        chk("R8 rot x kept", {31'h0, flag_x, flag_c, 30'h0} >> 30, 32'h1);
        // R11 rotate through extend, word left by 17 returns operand
        apply(mk(3'd0, 1'b1, 2'b01, 1'b1, 2'b10, 3'd0), 32'h0000_8001, 32'd17, 1'b1, "R11 ring");
        chk("R11 ring value", result, 32'h0000_8001);
        // R4 direction right of plain rotate byte
        apply(mk(3'd1, 1'b0, 2'b00, 1'b0, 2'b11, 3'd0), 32'h0000_0003, 0, 1'b0, "R4 ror");
        chk("R4 ror value", result, 32'h0000_0081);

        // R1 illegal opcode and size
        held = result;
        @(negedge clk);
        instr = 16'hD000; in_valid = 1'b1; dst_val = 32'hFFFF_FFFF;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 bad opcode illegal", {30'h0, out_illegal, out_valid}, 32'h2);
        chk("R1 bad opcode hold", result, held);
        @(negedge clk);
        instr = mk(3'd1, 1'b1, 2'b11, 1'b0, 2'b01, 3'd0); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
        chk("R1 bad size illegal", {30'h0, out_illegal, out_valid}, 32'h2);
        chk("R1 bad size hold", result, held);
        @(negedge clk);
        chk("R12 one-cycle valid", {30'h0, out_illegal, out_valid}, 32'h0);

        void'($urandom(32'd1234));
        for (int i = 0; i < 2500; i++) begin
            iw = $urandom;
            iw[15:12] = 4'b1110;
            if (iw[7:6] == 2'b11) iw[7:6] = $urandom_range(0, 2);
            apply(iw, $urandom, $urandom, 1'($urandom), "R5 random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule